// File: doc/BRIEF.md
# Password-Locked Block Access Controller

This controller decides, for each block of a word-organised nonvolatile store, whether the current requester may read or write it. Each block can be given a password of one to three 32-bit words, a protection mode and a supervisor-only flag. Any block except block 0 can also be hidden until the next reset. Block 0 has a special role. Its lock state gates every other block, and its protection flags are merged into the flags of every other block.

Software reaches the controller through one register port. A block is first chosen with the select register. The other registers then act on that block: three password slots, an unlock register, a protection register and a hide register. The access verdict for the selected block (`acc_rd_ok`, `acc_wr_ok`) and its open state are computed combinationally from registered state. Any change made by a register write is therefore visible from the cycle after that write.

The multiword unlock is tracked by a sequencer with four states. SQ_IDLE means no word has been matched yet. SQ_ONE means one word has been matched. SQ_TWO means two words have been matched. SQ_BAD means a wrong word was seen. Its transitions are:
- A matching word that is not the last one moves SQ_IDLE to SQ_ONE, or SQ_ONE to SQ_TWO.
- A matching final word returns to SQ_IDLE and unlocks the block.
- A wrong word moves any matching state to SQ_BAD, and SQ_BAD holds there.
- A restart word (all ones) or a valid select write returns every state to SQ_IDLE.

Top module: `pwacc_lock_ctrl`

## Requirements
- R1: Register addresses 1, 2 and 3 are password slots 0, 1 and 2. A slot write is accepted only when all of these hold:
  - the word is not 0xFFFFFFFF;
  - the slot number equals the count of words already stored for the selected block;
  - for slots 1 and 2, the previous register write was the accepted write of the slot just before it.
  Every other password write is rejected and stored words never change, so a password can be set only once.
- R2: Writing 0xFFFFFFFF to the unlock register (address 4) locks the selected block if it has a password, and restarts the unlock sequence. When the selected block is 0, the same write locks every block that has a password.
- R3: To unlock, the password words are written to the unlock register one by one, from the highest stored slot down to slot 0. The block becomes unlocked on the clock edge after the final matching word. A wrong word leaves the block locked until a restart. A sequence shorter than the stored length leaves it locked.
- R4: `blk_open`, and bit 0 of a read of address 4, are 1 when the selected block has no password or is unlocked, and 0 when it is locked.
- R5: Storing the first password word leaves the block unlocked. It stays unlocked until it is locked itself, block 0 is locked, or a reset occurs.
- R6: While block 0 is locked, every other block gets neither read nor write access.
- R7: The protection register (address 5) holds the mode in bits [1:0] and the supervisor-only flag in bit 2. For block N ≥ 1, the effective flags are the bitwise OR of block 0's flags and block N's flags. Reads of address 5 return the selected block's own flags.
- R8: The modes are applied as follows:
  - Mode 0: read/write, except read-only when the block is locked.
  - Mode 1: read/write only when a password is set and the block is unlocked; otherwise no access.
  - Mode 2: read-only, except no access when the block is locked.
  - Mode 3: no access.
  With the supervisor-only flag set, a requester with `req_priv`=0 gets no access. Write permission is never granted without read permission.
- R9: A write to the hide register (address 6) is accepted only when the mask has exactly one bit set, that bit is not bit 0, and no bit at or above NUM_BLK is set. Hidden blocks get no access until reset, and a hidden block never becomes visible again before reset. Rejected masks change nothing.
- R10: A protection write is accepted only when the selected block is open and, for blocks other than 0, block 0 is also open. Otherwise it is rejected and the flags keep their value.
- R11: A write to the select register (address 0) with a value of NUM_BLK or more is rejected, and the selection is kept. A valid select write restarts the unlock sequence. Address 0 reads back the selection.
- R12: After reset the selection is block 0, no block has a password or is hidden, all flags are zero, and `cfg_err` is 0. `cfg_err` shows whether the latest register write was rejected. Address 7 is reserved: writes to it have no effect and raise no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for both write and read |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |
| req_priv | input | 1 | Requester holds supervisor privilege |
| acc_rd_ok | output | 1 | Read permitted on the selected block |
| acc_wr_ok | output | 1 | Write permitted on the selected block |
| blk_open | output | 1 | Selected block unlocked or without password |
| cfg_err | output | 1 | Latest register write was rejected |

## Verification
Only one register write happens per cycle, so the overlaps that matter come from a single write acting on two things at once. A restart word on block 0 locks that block, locks every other block and resets a partly entered sequence, all on the same edge. The bench provokes this by locking block 0 while another block is unlocked or halfway through its sequence. It then judges the other block's open state and verdict against a model of the requirements. A valid select write likewise abandons a sequence in progress while changing whose state is reported. The bench therefore mixes random selects between unlock words. The expected verdict is checked after every write for both privilege levels.

// File: rtl/pwacc_pkg.sv
package pwacc_pkg;

    localparam int PW_WORDS = 3;

    typedef enum logic [2:0] {
        RA_SEL  = 3'd0,
        RA_PW0  = 3'd1,
        RA_PW1  = 3'd2,
        RA_PW2  = 3'd3,
        RA_UNLK = 3'd4,
        RA_PROT = 3'd5,
        RA_HIDE = 3'd6,
        RA_RSVD = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        PM_OPEN_RW   = 2'd0,
        PM_KEY_ONLY  = 2'd1,
        PM_READ_ONLY = 2'd2,
        PM_BLOCKED   = 2'd3
    } prot_mode_e;

    typedef struct packed {
        logic       sup_only;
        logic [1:0] mode;
    } prot_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_ONE  = 2'd1,
        SQ_TWO  = 2'd2,
        SQ_BAD  = 2'd3
    } seq_e;

endpackage

// File: rtl/pwacc_unlock_fsm.sv
module pwacc_unlock_fsm
    import pwacc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       word_vld,
    input  logic       word_hit,
    input  logic [1:0] pw_len,
    output logic [1:0] depth,
    output logic       unlock_now
);

    seq_e st_q, st_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SQ_IDLE;
        else        st_q <= st_nxt;
    end

    // next state
    always_comb begin
        st_nxt = st_q;
        if (restart) begin
            st_nxt = SQ_IDLE;
        end else if (word_vld) begin
            unique case (st_q)
                SQ_IDLE: st_nxt = !word_hit ? SQ_BAD : ((pw_len == 2'd1) ? SQ_IDLE : SQ_ONE);
                SQ_ONE:  st_nxt = !word_hit ? SQ_BAD : ((pw_len == 2'd2) ? SQ_IDLE : SQ_TWO);
                SQ_TWO:  st_nxt = !word_hit ? SQ_BAD : SQ_IDLE;
                SQ_BAD:  st_nxt = SQ_BAD;
                default: st_nxt = SQ_BAD;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            SQ_ONE:  depth = 2'd1;
            SQ_TWO:  depth = 2'd2;
            default: depth = 2'd0;
        endcase
        unlock_now = word_vld && !restart && word_hit && (st_q != SQ_BAD)
                     && (2'(depth + 2'd1) == pw_len);
    end

    AST_SEQ_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q == SQ_IDLE)); // R2
    AST_BAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SQ_BAD && !restart) |=> (st_q == SQ_BAD)); // R3
    AST_UNLOCK_NOT_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        unlock_now |=> (st_q == SQ_IDLE)); // R3

endmodule

// File: rtl/pwacc_perm_eval.sv
module pwacc_perm_eval
    import pwacc_pkg::*;
(
    input  logic  blk0_sel,
    input  logic  blk0_open,
    input  logic  hidden,
    input  prot_t own_prot,
    input  prot_t glob_prot,
    input  logic  own_has_pw,
    input  logic  own_open,
    input  logic  priv,
    output logic  rd_ok,
    output logic  wr_ok
);

    logic [1:0] eff_mode;
    logic       eff_sup;
    logic       locked;
    logic       deny;
    logic       base_rd, base_wr;

    always_comb begin
        eff_mode = own_prot.mode | (blk0_sel ? 2'b00 : glob_prot.mode);
        eff_sup  = own_prot.sup_only | (!blk0_sel && glob_prot.sup_only);
        locked   = own_has_pw && !own_open;
        unique case (prot_mode_e'(eff_mode))
            PM_OPEN_RW: begin
                base_rd = 1'b1;
                base_wr = !locked;
            end
            PM_KEY_ONLY: begin
                base_rd = own_has_pw && own_open;
                base_wr = own_has_pw && own_open;
            end
            PM_READ_ONLY: begin
                base_rd = !locked;
                base_wr = 1'b0;
            end
            default: begin
                base_rd = 1'b0;
                base_wr = 1'b0;
            end
        endcase
        deny  = (!blk0_sel && !blk0_open) || hidden || (eff_sup && !priv);
        rd_ok = base_rd && !deny;
        wr_ok = base_wr && !deny;
    end

endmodule

// File: rtl/pwacc_lock_ctrl.sv
module pwacc_lock_ctrl
    import pwacc_pkg::*;
#(
    parameter int NUM_BLK = 4,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              req_priv,
    output logic              acc_rd_ok,
    output logic              acc_wr_ok,
    output logic              blk_open,
    output logic              cfg_err
);

    localparam int SEL_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1;
    localparam int LEN_W = 2;

    logic [SEL_W-1:0]  sel_q;
    logic [DATA_W-1:0] pw_q  [NUM_BLK][PW_WORDS];
    logic [LEN_W-1:0]  len_q [NUM_BLK];
    logic              unl_q [NUM_BLK];
    prot_t             prot_q[NUM_BLK];
    logic [NUM_BLK-1:0] hid_q;
    logic              err_q;
    logic              pw_open_q;

    logic [NUM_BLK-1:0] has_pw, open_v;

    reg_addr_e         ra;
    logic              wr_sel, wr_pw, wr_unl, wr_prot, wr_hide;
    logic              is_ones, sel_ok, pw_ok, prot_ok, hide_ok;
    logic [1:0]        pw_k;
    logic [LEN_W-1:0]  cur_len;
    logic [1:0]        seq_depth, exp_idx;
    logic [DATA_W-1:0] exp_w;
    logic [NUM_BLK-1:0] hmask;
    logic              seq_restart, seq_word_vld, seq_unlock;
    logic              lock_one, lock_all;

    // ---------------- decode ----------------
    always_comb begin
        ra      = reg_addr_e'(reg_addr);
        wr_sel  = reg_wr && (ra == RA_SEL);
        wr_pw   = reg_wr && ((ra == RA_PW0) || (ra == RA_PW1) || (ra == RA_PW2));
        wr_unl  = reg_wr && (ra == RA_UNLK);
        wr_prot = reg_wr && (ra == RA_PROT);
        wr_hide = reg_wr && (ra == RA_HIDE);
        is_ones = &reg_wdata;
        pw_k    = reg_addr[1:0] - 2'd1;
        cur_len = len_q[sel_q];
        sel_ok  = reg_wdata < DATA_W'(NUM_BLK);
        pw_ok   = wr_pw && !is_ones && (cur_len == pw_k) && ((pw_k == 2'd0) || pw_open_q);
        prot_ok = open_v[sel_q] && ((sel_q == '0) || open_v[0]);
        hmask   = reg_wdata[NUM_BLK-1:0];
        hide_ok = $onehot(hmask) && !hmask[0] && ((reg_wdata >> NUM_BLK) == '0);
        exp_idx = cur_len - 2'd1 - seq_depth;
        case (exp_idx)
            2'd2:    exp_w = pw_q[sel_q][2];
            2'd1:    exp_w = pw_q[sel_q][1];
            default: exp_w = pw_q[sel_q][0];
        endcase
        seq_restart  = (wr_unl && is_ones) || (wr_sel && sel_ok);
        seq_word_vld = wr_unl && !is_ones && has_pw[sel_q];
        lock_one     = wr_unl && is_ones;
        lock_all     = lock_one && (sel_q == '0);
    end

    pwacc_unlock_fsm u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (seq_restart),
        .word_vld   (seq_word_vld),
        .word_hit   (reg_wdata == exp_w),
        .pw_len     (cur_len),
        .depth      (seq_depth),
        .unlock_now (seq_unlock)
    );

    // ---------------- global registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q     <= '0;
            hid_q     <= '0;
            err_q     <= 1'b0;
            pw_open_q <= 1'b0;
        end else begin
            if (wr_sel && sel_ok) sel_q <= reg_wdata[SEL_W-1:0];
            if (wr_hide && hide_ok) hid_q <= hid_q | hmask;
            if (reg_wr) begin
                err_q <= (wr_sel && !sel_ok) || (wr_pw && !pw_ok)
                       || (wr_prot && !prot_ok) || (wr_hide && !hide_ok);
                pw_open_q <= pw_ok && (pw_k != 2'd2);
            end
        end
    end

    // ---------------- per-block registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NUM_BLK; b++) begin
                len_q[b]  <= '0;
                unl_q[b]  <= 1'b0;
                prot_q[b] <= '0;
                for (int w = 0; w < PW_WORDS; w++) pw_q[b][w] <= '0;
            end
        end else begin
            for (int b = 0; b < NUM_BLK; b++) begin
                if (pw_ok && (sel_q == SEL_W'(b))) begin
                    pw_q[b][pw_k] <= reg_wdata;
                    len_q[b]      <= len_q[b] + 1'b1;
                    unl_q[b]      <= 1'b1;
                end else if (seq_unlock && (sel_q == SEL_W'(b))) begin
                    unl_q[b] <= 1'b1;
                end else if (lock_all || (lock_one && (sel_q == SEL_W'(b)))) begin
                    unl_q[b] <= 1'b0;
                end
                if (wr_prot && prot_ok && (sel_q == SEL_W'(b)))
                    prot_q[b] <= prot_t'(reg_wdata[2:0]);
            end
        end
    end

    for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
        assign has_pw[b] = (len_q[b] != '0);
        assign open_v[b] = !has_pw[b] || unl_q[b];

        AST_PW_NOT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
            has_pw[b] |-> (pw_q[b][0] != '1)); // R1
        AST_PW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
            has_pw[b] |=> (pw_q[b][0] == $past(pw_q[b][0]))); // R1
        AST_UNLOCK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
            (seq_unlock && sel_q == SEL_W'(b)) |=> open_v[b]); // R3
    end

    // ---------------- verdict ----------------
    pwacc_perm_eval u_perm (
        .blk0_sel   (sel_q == '0),
        .blk0_open  (open_v[0]),
        .hidden     (hid_q[sel_q]),
        .own_prot   (prot_q[sel_q]),
        .glob_prot  (prot_q[0]),
        .own_has_pw (has_pw[sel_q]),
        .own_open   (open_v[sel_q]),
        .priv       (req_priv),
        .rd_ok      (acc_rd_ok),
        .wr_ok      (acc_wr_ok)
    );

    assign blk_open = open_v[sel_q];
    assign cfg_err  = err_q;

    always_comb begin
        reg_rdata = '0;
        case (ra)
            RA_SEL:  reg_rdata = DATA_W'(sel_q);
            RA_UNLK: reg_rdata[0] = open_v[sel_q];
            RA_PROT: reg_rdata[2:0] = prot_q[sel_q];
            RA_HIDE: reg_rdata[NUM_BLK-1:0] = hid_q;
            default: reg_rdata = '0;
        endcase
    end

    AST_GATE_BLK0: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q != '0 && !open_v[0]) |-> (!acc_rd_ok && !acc_wr_ok)); // R6
    AST_WR_NEEDS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr_ok |-> acc_rd_ok); // R8
    AST_HIDE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((hid_q & $past(hid_q)) == $past(hid_q))); // R9
    AST_HIDDEN_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        hid_q[sel_q] |-> (!acc_rd_ok && !acc_wr_ok)); // R9

endmodule

// File: tb/pwacc_lock_ctrl_tb.sv
`timescale 1ns/1ps
module pwacc_lock_ctrl_tb;

    localparam int NB = 4;
    localparam logic [2:0] A_SEL = 3'd0, A_PW0 = 3'd1, A_PW1 = 3'd2, A_PW2 = 3'd3,
                           A_UNLK = 3'd4, A_PROT = 3'd5, A_HIDE = 3'd6, A_RSVD = 3'd7;
    localparam logic [31:0] ONES = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        req_priv = 1'b0;
    logic        acc_rd_ok, acc_wr_ok, blk_open, cfg_err;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwacc_lock_ctrl #(.NUM_BLK(NB), .DATA_W(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_priv(req_priv),
        .acc_rd_ok(acc_rd_ok), .acc_wr_ok(acc_wr_ok), .blk_open(blk_open),
        .cfg_err(cfg_err)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_pw [NB][3];
    int          m_len [NB];
    bit          m_unl [NB];
    logic [2:0]  m_prot [NB];
    logic [NB-1:0] m_hid;
    int          m_sel, m_depth;
    bit          m_bad, m_err, m_pwopen;

    function automatic bit m_open(int b);
        return (m_len[b] == 0) || m_unl[b];
    endfunction

    function automatic logic [1:0] exp_perm(bit priv);
        logic [1:0] md;
        bit sup, lk;
        int s;
        s = m_sel;
        if (s != 0 && !m_open(0)) return 2'b00;
        if (m_hid[s]) return 2'b00;
        md  = m_prot[s][1:0] | ((s != 0) ? m_prot[0][1:0] : 2'b00);
        sup = m_prot[s][2] | ((s != 0) ? m_prot[0][2] : 1'b0);
        if (sup && !priv) return 2'b00;
        lk = (m_len[s] > 0) && !m_unl[s];
        case (md)
            2'd0: return lk ? 2'b10 : 2'b11;
            2'd1: return (m_len[s] > 0 && !lk) ? 2'b11 : 2'b00;
            2'd2: return lk ? 2'b00 : 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    task automatic model_reset();
        for (int b = 0; b < NB; b++) begin
            m_len[b] = 0; m_unl[b] = 0; m_prot[b] = 3'd0;
            for (int w = 0; w < 3; w++) m_pw[b][w] = 32'd0;
        end
        m_hid = '0; m_sel = 0; m_depth = 0; m_bad = 0; m_err = 0; m_pwopen = 0;
    endtask

    task automatic model_write(logic [2:0] a, logic [31:0] d);
        bit err, nopen;
        int k;
        err = 0; nopen = 0;
        case (a)
            A_SEL: if (d < NB) begin m_sel = int'(d); m_depth = 0; m_bad = 0; end
                   else err = 1;
            A_PW0, A_PW1, A_PW2: begin
                k = int'(a) - 1;
                if (d != ONES && m_len[m_sel] == k && (k == 0 || m_pwopen)) begin
                    m_pw[m_sel][k] = d; m_len[m_sel]++; m_unl[m_sel] = 1; nopen = (k < 2);
                end else err = 1;
            end
            A_UNLK: begin
                if (d == ONES) begin
                    m_depth = 0; m_bad = 0;
                    if (m_sel == 0) begin
                        for (int b = 0; b < NB; b++) if (m_len[b] > 0) m_unl[b] = 0;
                    end else if (m_len[m_sel] > 0) m_unl[m_sel] = 0;
                end else if (m_len[m_sel] > 0 && !m_bad) begin
                    if (d == m_pw[m_sel][m_len[m_sel] - 1 - m_depth]) begin
                        if (m_depth + 1 == m_len[m_sel]) begin m_unl[m_sel] = 1; m_depth = 0; end
                        else m_depth++;
                    end else m_bad = 1;
                end
            end
            A_PROT: if (m_open(m_sel) && (m_sel == 0 || m_open(0))) m_prot[m_sel] = d[2:0];
                    else err = 1;
            A_HIDE: if ($onehot(d) && !d[0] && (d >> NB) == 0) m_hid = m_hid | d[NB-1:0];
                    else err = 1;
            default: ;
        endcase
        m_err = err; m_pwopen = nopen;
    endtask

    // ---------------- checking ----------------
    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        logic [1:0] e;
        for (int p = 0; p < 2; p++) begin
            req_priv = p[0];
            reg_addr = A_UNLK;
            #0.4;
            e = exp_perm(p[0]);
            chk("R8 read verdict", 32'(acc_rd_ok), 32'(e[1]));
            chk("R8 write verdict", 32'(acc_wr_ok), 32'(e[0]));
        end
        chk("R4 open state", 32'(blk_open), 32'(m_open(m_sel)));
        chk("R4 unlock readback", reg_rdata, 32'(m_open(m_sel)));
        chk("R12 error flag", 32'(cfg_err), 32'(m_err));
        reg_addr = A_PROT; #0.4;
        chk("R7 flag readback", reg_rdata, 32'(m_prot[m_sel]));
        reg_addr = A_SEL; #0.4;
        chk("R11 select readback", reg_rdata, 32'(m_sel));
        reg_addr = A_HIDE; #0.4;
        chk("R9 hide readback", reg_rdata, 32'(m_hid));
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        model_write(a, d);
        check_all();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all();
    endtask

    task automatic expect_bit(string tag, logic act, logic exp);
        chk(tag, 32'(act), 32'(exp));
    endtask

    // ---------------- stimulus ----------------
    logic [31:0] pool [4] = '{32'h1111_0001, 32'h2222_0002, 32'h3333_0003, 32'h4444_0004};

    initial begin
        void'($urandom(32'd20240607));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all();
        req_priv = 1'b0; reg_addr = A_UNLK; #0.4;
        expect_bit("R12 reset full read", acc_rd_ok, 1'b1);
        expect_bit("R12 reset full write", acc_wr_ok, 1'b1);

        // R1 / R5: two-word password on block 1
        wr(A_SEL, 32'd1);
        wr(A_PW0, 32'h11); wr(A_PW1, 32'h22);
        expect_bit("R5 open after set", blk_open, 1'b1);
        wr(A_PW0, 32'h33);
        expect_bit("R1 second set rejected", cfg_err, 1'b1);
        wr(A_PW2, 32'h33);
        expect_bit("R1 non-consecutive slot rejected", cfg_err, 1'b1);
        // R2 lock
        wr(A_UNLK, ONES);
        expect_bit("R2 locked", blk_open, 1'b0);
        expect_bit("R8 mode0 locked no write", acc_wr_ok, 1'b0);
        // R3 wrong order
        wr(A_UNLK, 32'h11); wr(A_UNLK, 32'h22);
        expect_bit("R3 wrong order stays locked", blk_open, 1'b0);
        wr(A_UNLK, ONES); wr(A_UNLK, 32'h22);
        expect_bit("R3 partial sequence locked", blk_open, 1'b0);
        wr(A_UNLK, 32'h11);
        expect_bit("R3 reverse order unlocks", blk_open, 1'b1);
        // block 2: ones rejected, mode 2, protection write while locked
        wr(A_SEL, 32'd2);
        wr(A_PW0, ONES);
        expect_bit("R1 all-ones word rejected", cfg_err, 1'b1);
        wr(A_PW0, 32'h44);
        wr(A_PROT, 32'd2);
        expect_bit("R8 mode2 no write", acc_wr_ok, 1'b0);
        wr(A_UNLK, ONES);
        expect_bit("R8 mode2 locked no read", acc_rd_ok, 1'b0);
        wr(A_PROT, 32'd0);
        expect_bit("R10 protect write while locked", cfg_err, 1'b1);
        // supervisor flag on block 0 merges into block 1
        wr(A_SEL, 32'd0); wr(A_PROT, 32'd4);
        wr(A_SEL, 32'd1);
        req_priv = 1'b0; #0.4;
        expect_bit("R7 merged supervisor flag", acc_rd_ok, 1'b0);
        wr(A_SEL, 32'd0); wr(A_PROT, 32'd0);
        // block 0 password and global lock
        wr(A_PW0, 32'h55);
        wr(A_UNLK, ONES);
        wr(A_SEL, 32'd1);
        expect_bit("R5 block0 lock locks others", blk_open, 1'b0);
        expect_bit("R6 block0 locked denies", acc_rd_ok, 1'b0);
        wr(A_PROT, 32'd0);
        expect_bit("R10 block0 locked rejects", cfg_err, 1'b1);
        wr(A_SEL, 32'd0); wr(A_UNLK, 32'h55);
        wr(A_SEL, 32'd1);
        expect_bit("R6 block1 readable after block0 unlock", acc_rd_ok, 1'b1);
        // OR of modes
        wr(A_SEL, 32'd0); wr(A_PROT, 32'd1);
        wr(A_SEL, 32'd3);
        expect_bit("R7 key-only inherited", acc_rd_ok, 1'b0);
        wr(A_SEL, 32'd0); wr(A_PROT, 32'd0);
        // hide
        wr(A_HIDE, 32'h1);
        expect_bit("R9 block0 hide rejected", cfg_err, 1'b1);
        wr(A_HIDE, 32'hC);
        expect_bit("R9 multi-bit rejected", cfg_err, 1'b1);
        wr(A_HIDE, 32'h8);
        wr(A_SEL, 32'd3);
        expect_bit("R9 hidden denied", acc_rd_ok, 1'b0);
        wr(A_SEL, 32'd5);
        expect_bit("R11 bad select rejected", cfg_err, 1'b1);
        wr(A_RSVD, 32'hDEAD);
        expect_bit("R12 reserved no error", cfg_err, 1'b0);

        // ---------------- constrained random ----------------
        for (int i = 0; i < 3000; i++) begin
            int r;
            logic [31:0] d;
            if (i % 500 == 0) do_reset();
            r = int'($urandom_range(0, 99));
            if (r < 15)      wr(A_SEL, 32'($urandom_range(0, 4)));
            else if (r < 35) begin
                d = ($urandom_range(0, 7) == 0) ? ONES : pool[$urandom_range(0, 3)];
                wr(3'(1 + $urandom_range(0, 2)), d);
            end else if (r < 75) begin
                d = ($urandom_range(0, 2) == 0) ? ONES : pool[$urandom_range(0, 3)];
                wr(A_UNLK, d);
            end else if (r < 92) begin
                d = $urandom & 32'hFFFF_FFF8;
                d[1:0] = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'd0;
                d[2]   = ($urandom_range(0, 7) == 0);
                wr(A_PROT, d);
            end else if (r < 94) wr(A_HIDE, 32'd1 << $urandom_range(0, 5));
            else if (r < 96)     wr(A_RSVD, $urandom);
            else begin
                @(negedge clk);
                check_all();
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_bad++;
            $display("FAIL R12 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule